// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is the combinational bit-manipulation datapath of an 8-bit CPU core. It runs every operation of the bit-operation opcode page, which a prefix byte selects. It also runs the four single-byte accumulator rotates. The instruction sequencer passes in the second opcode byte, the operand byte and the current flags. The unit returns the result byte, the new flags and a flag that says whether the result must be written back.

The sequencer raises `fastSel` when the instruction is one of the short accumulator rotates. In that mode only opcode bits 4:3 choose the rotate, and the Z flag is always cleared. In prefixed mode the whole byte is decoded. Bits 7:6 pick the group: 00 for shift/rotate/swap, 01 for bit test, 10 for bit clear and 11 for bit set. Bits 5:3 give the sub-operation or the bit index.

The flag nibble is laid out with Z in bit 3, N in bit 2, H in bit 1 and C in bit 0. Register addressing, memory operands and cycle timing are handled outside this block.

Top module: `rsb_unit`

## Requirements
- R1: In prefixed mode, opcode bits 7:6 select the group: 00 = shift/rotate/swap, 01 = bit test, 10 = bit clear, 11 = bit set. For groups 01, 10 and 11, bits 5:3 give the bit index.
- R2: In the shift group, sub-operation 000 rotates left and 001 rotates right. The bit leaving the byte goes both into C and into the vacated bit position.
- R3: Sub-operation 010 rotates left and 011 rotates right through carry. The old C enters the vacated bit, and the leaving bit becomes the new C.
- R4: Sub-operation 100 shifts left with a 0 entering bit 0. Sub-operation 101 shifts right and keeps bit 7 at its old value. Sub-operation 111 shifts right with a 0 entering bit 7. In all three, the leaving bit goes to C.
- R5: Sub-operation 110 exchanges the high and low nibbles and clears C.
- R6: Every shift-group operation sets Z when the result is zero and clears N and H.
- R7: With `fastSel` high, opcode bits 4:3 pick 00 = rotate left, 01 = rotate right, 10 = rotate left through carry, 11 = rotate right through carry. The other opcode bits are ignored. Z, N and H are cleared and C takes the leaving bit.
- R8: Bit test sets Z when the selected operand bit is 0, clears N, sets H and keeps C. Its result equals the operand.
- R9: Bit clear and bit set force the selected bit to 0 or 1 and leave all four flags unchanged.
- R10: `writeEn` is low for bit test and high for every other operation, including the accumulator rotates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastSel | input | 1 | High selects the single-byte accumulator rotates |
| opByte | input | 8 | Second opcode byte, or the rotate opcode when fastSel is high |
| operand | input | 8 | Operand byte |
| flagsIn | input | 4 | Incoming flags {Z,N,H,C} |
| result | output | 8 | Result byte |
| flagsOut | output | 4 | New flags {Z,N,H,C} |
| writeEn | output | 1 | Result must be written back |

## Verification
Some properties can be checked on every input combination. The checker does this for the following:
- The flags that must be preserved by bit test, bit clear and bit set.
- The cleared Z, N and H of the accumulator rotates.
- Z agreeing with a zero result in the shift group.
- The cleared carry and conserved population count of the nibble swap.
- The write-enable rule.

The exact bit movements cannot be checked that way: which bit leaves, what enters the vacated position, and the sign-keeping right shift. Only the bench's sweep can show these. It runs all 256 opcode bytes over several operands with carry both clear and set, and compares each result against an independent reference model.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int DATA_W = 8;
  localparam int OPC_W  = 8;
  localparam int FLAG_W = 4;
  localparam int SEL_W  = 3;
  // flag nibble positions
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [SEL_W-1:0] {
    SH_ROL_C  = 3'd0,
    SH_ROR_C  = 3'd1,
    SH_ROL_TC = 3'd2,
    SH_ROR_TC = 3'd3,
    SH_LSL    = 3'd4,
    SH_ASR    = 3'd5,
    SH_NSWAP  = 3'd6,
    SH_LSR    = 3'd7
  } shiftOp_e;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } group_e;

  typedef struct packed {
    logic           fast;
    group_e         grp;
    shiftOp_e       shOp;
    logic [SEL_W-1:0] bitIdx;
    logic           wrEn;
  } ctrl_t;
endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
  import rsb_pkg::*;
#(
  parameter int OPW = OPC_W
) (
  input  logic           fastSel,
  input  logic [OPW-1:0] opByte,
  output ctrl_t          ctrl
);
  localparam int GRP_LSB = OPW - 2;
  localparam int SEL_LSB = 3;

  logic [1:0]       grpField;
  logic [SEL_W-1:0] selField;

  assign grpField = opByte[OPW-1:GRP_LSB];
  assign selField = opByte[SEL_LSB +: SEL_W];

  always_comb begin
    ctrl        = '0;
    ctrl.fast   = fastSel;
    ctrl.bitIdx = selField;
    if (fastSel) begin
      ctrl.grp  = GRP_SHIFT;
      ctrl.shOp = shiftOp_e'({1'b0, selField[1:0]});
    end else begin
      ctrl.grp  = group_e'(grpField);
      ctrl.shOp = shiftOp_e'(selField);
    end
    ctrl.wrEn = (ctrl.grp != GRP_TEST);
  end
endmodule

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  ctrl_t              ctrl,
  input  logic [W-1:0]       operand,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic [W-1:0]       result,
  output logic [FLAG_W-1:0]  flagsOut
);
  localparam int HALF_W = W / 2;

  logic [W-1:0] bitMask;
  logic [W-1:0] shRes;
  logic         shCarry;
  logic         carryIn;
  logic         selBit;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_mask
      assign bitMask[gi] = (ctrl.bitIdx == SEL_W'(gi));
    end
  endgenerate

  assign carryIn = flagsIn[FC];
  assign selBit  = |(operand & bitMask);

  always_comb begin
    shRes   = operand;
    shCarry = 1'b0;
    unique case (ctrl.shOp)
      SH_ROL_C: begin
        shRes   = {operand[W-2:0], operand[W-1]};
        shCarry = operand[W-1];
      end
      SH_ROR_C: begin
        shRes   = {operand[0], operand[W-1:1]};
        shCarry = operand[0];
      end
      SH_ROL_TC: begin
        shRes   = {operand[W-2:0], carryIn};
        shCarry = operand[W-1];
      end
      SH_ROR_TC: begin
        shRes   = {carryIn, operand[W-1:1]};
        shCarry = operand[0];
      end
      SH_LSL: begin
        shRes   = {operand[W-2:0], 1'b0};
        shCarry = operand[W-1];
      end
      SH_ASR: begin
        shRes   = {operand[W-1], operand[W-1:1]};
        shCarry = operand[0];
      end
      SH_NSWAP: begin
        shRes   = {operand[HALF_W-1:0], operand[W-1:HALF_W]};
        shCarry = 1'b0;
      end
      SH_LSR: begin
        shRes   = {1'b0, operand[W-1:1]};
        shCarry = operand[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    result   = operand;
    flagsOut = flagsIn;
    unique case (ctrl.grp)
      GRP_SHIFT: begin
        result       = shRes;
        flagsOut[FZ] = ctrl.fast ? 1'b0 : (shRes == '0);
        flagsOut[FN] = 1'b0;
        flagsOut[FH] = 1'b0;
        flagsOut[FC] = shCarry;
      end
      GRP_TEST: begin
        flagsOut[FZ] = ~selBit;
        flagsOut[FN] = 1'b0;
        flagsOut[FH] = 1'b1;
      end
      GRP_CLR: result = operand & ~bitMask;
      GRP_SET: result = operand | bitMask;
      default: ;
    endcase
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic              fastSel,
  input  logic [OPC_W-1:0]  opByte,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              writeEn
);
  ctrl_t ctrl;

  rsb_decode #(.OPW(OPC_W)) u_decode (
    .fastSel(fastSel),
    .opByte (opByte),
    .ctrl   (ctrl)
  );

  rsb_datapath #(.W(DATA_W)) u_datapath (
    .ctrl    (ctrl),
    .operand (operand),
    .flagsIn (flagsIn),
    .result  (result),
    .flagsOut(flagsOut)
  );

  assign writeEn = ctrl.wrEn;
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk
  import rsb_pkg::*;
(
  input logic              fastSel,
  input logic [OPC_W-1:0]  opByte,
  input logic [DATA_W-1:0] operand,
  input logic [FLAG_W-1:0] flagsIn,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flagsOut,
  input logic              writeEn
);
  logic known;
  logic isTest, isBitWr, isShift, isSwap;

  assign known   = !$isunknown({fastSel, opByte, operand, flagsIn, result, flagsOut, writeEn});
  assign isTest  = !fastSel && opByte[7:6] == 2'b01;
  assign isBitWr = !fastSel && opByte[7];
  assign isShift = !fastSel && opByte[7:6] == 2'b00;
  assign isSwap  = isShift && opByte[5:3] == 3'b110;

  always_comb begin
    if (known) begin
      assert_test_flags_R8: assert (!isTest || (flagsOut[FC] == flagsIn[FC] && flagsOut[FH] && !flagsOut[FN]))
        else $error("bit test flag rule broken");
      assert_bitwr_flags_R9: assert (!isBitWr || flagsOut == flagsIn)
        else $error("bit clear/set altered flags");
      assert_fast_flags_R7: assert (!fastSel || flagsOut[FZ:FH] == 3'b000)
        else $error("accumulator rotate left Z/N/H set");
      assert_shift_zero_R6: assert (!isShift || (flagsOut[FZ] == (result == '0) && flagsOut[FN:FH] == 2'b00))
        else $error("shift group Z/N/H wrong");
      assert_swap_keep_R5: assert (!isSwap || (!flagsOut[FC] && $countones(result) == $countones(operand)))
        else $error("swap lost bits or kept carry");
      assert_write_rule_R10: assert (writeEn == !isTest)
        else $error("write enable rule broken");
    end
  end
endmodule

bind rsb_unit rsb_unit_chk chk (
  .fastSel (fastSel),
  .opByte  (opByte),
  .operand (operand),
  .flagsIn (flagsIn),
  .result  (result),
  .flagsOut(flagsOut),
  .writeEn (writeEn)
);

// File: tb/rsb_unit_test.sv
`timescale 1ns/1ps
module rsb_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fastSel = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [3:0] flagsIn = 4'h0;
  logic [7:0] result;
  logic [3:0] flagsOut;
  logic       writeEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit         fast;
    logic [7:0] op;
    logic [7:0] res;
    logic [3:0] flg;
    logic       we;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #2.5 clk = ~clk;

  rsb_unit uut (
    .fastSel (fastSel),
    .opByte  (opByte),
    .operand (operand),
    .flagsIn (flagsIn),
    .result  (result),
    .flagsOut(flagsOut),
    .writeEn (writeEn)
  );

  // Independent reference model of the requirements
  function automatic item_t model(bit f, logic [7:0] op, logic [7:0] a, logic [3:0] fi);
    item_t it;
    logic [2:0] s;
    logic c;
    logic [7:0] r;
    it.fast = f; it.op = op; it.res = a; it.flg = fi; it.we = 1'b1;
    s = op[5:3];
    if (f || op[7:6] == 2'b00) begin
      if (f) s = {1'b0, op[4:3]};                  // R7: only bits 4:3 matter
      c = 1'b0; r = a;
      case (s)
        3'd0: begin c = a[7]; r = (a << 1) | {7'd0, a[7]}; it.tag = "R2"; end
        3'd1: begin c = a[0]; r = (a >> 1) | {a[0], 7'd0}; it.tag = "R2"; end
        3'd2: begin c = a[7]; r = (a << 1) | {7'd0, fi[0]}; it.tag = "R3"; end
        3'd3: begin c = a[0]; r = (a >> 1) | {fi[0], 7'd0}; it.tag = "R3"; end
        3'd4: begin c = a[7]; r = a << 1; it.tag = "R4"; end
        3'd5: begin c = a[0]; r = (a >> 1) | (a & 8'h80); it.tag = "R4"; end
        3'd6: begin c = 1'b0; r = {a[3:0], a[7:4]}; it.tag = "R5"; end
        default: begin c = a[0]; r = a >> 1; it.tag = "R4"; end
      endcase
      it.res = r;
      it.flg = {(f ? 1'b0 : (r == 8'd0)), 1'b0, 1'b0, c};  // R6 / R7
      if (f) it.tag = "R7";
    end else if (op[7:6] == 2'b01) begin           // R1 group 01 -> R8
      it.we  = 1'b0;
      it.flg = {~a[s], 1'b0, 1'b1, fi[0]};
      it.tag = "R8";
    end else begin                                  // R1 groups 10/11 -> R9
      it.res = a;
      it.res[s] = op[6];
      it.tag = "R9";
    end
    return it;
  endfunction

  task automatic drive(bit f, logic [7:0] op, logic [7:0] a, logic [3:0] fi);
    @(posedge clk);
    fastSel = f; opByte = op; operand = a; flagsIn = fi;
    sbq.push_back(model(f, op, a, fi));
  endtask

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp, string what, logic [7:0] op);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%02h actual=%02h expected=%02h", tag, what, op, act, exp);
    end
  endtask

  // Monitor: results are combinational, compared away from the driving edge
  always @(negedge clk) begin
    if (!rst && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      cmp(it.tag, result, it.res, "result", it.op);
      cmp((it.tag == "R8" || it.tag == "R9") ? it.tag : "R6", {4'd0, flagsOut}, {4'd0, it.flg}, "flags", it.op);
      cmp("R10", {7'd0, writeEn}, {7'd0, it.we}, "writeEn", it.op);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] vals [6];
    vals[0] = 8'h00; vals[1] = 8'h80; vals[2] = 8'h01;
    vals[3] = 8'hA5; vals[4] = 8'h3C; vals[5] = 8'hFF;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // initial state: opcode 00 on zero operand -> zero result, Z set (R6)
    @(negedge clk);
    cmp("R6", result, 8'h00, "idle result", 8'h00);
    cmp("R6", {4'd0, flagsOut}, 8'h08, "idle flags", 8'h00);
    // exhaustive prefixed sweep (R1..R6, R8..R10)
    for (int op = 0; op < 256; op++)
      for (int v = 0; v < 6; v++)
        for (int ci = 0; ci < 2; ci++)
          drive(1'b0, 8'(op), vals[v], (ci != 0) ? 4'b1111 : 4'b0000);
    // accumulator rotates with noise in unused opcode bits (R7)
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 6; v++)
        for (int ci = 0; ci < 2; ci++) begin
          drive(1'b1, {2'b00, 1'b0, 2'(k), 3'b111}, vals[v], ci ? 4'b1111 : 4'b0000);
          drive(1'b1, {2'b11, 1'b1, 2'(k), 3'b010}, vals[v], ci ? 4'b0111 : 4'b1000);
        end
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items", sbq.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule